// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Completion Accounting

This block holds the interrupt state of one DMA channel. Twelve event sources feed a sticky status register; software clears status bits by writing ones to them. A mask register, which software cannot write directly, gates which status bits reach the single level-sensitive interrupt output. The mask changes only through two write-only command offsets: one unmasks the bits written as one, the other masks them.

Two 8-bit accounting counters track completions. One counts source descriptor completions that carry an interrupt request, the other counts destination descriptor completions. Each completion also sets its done bit. When a counter wraps, its own overflow status bit is set. A read of a counter returns its value and clears it. Accesses to offsets the block does not decode raise an invalid-access status bit.

The data mover drives the event pulses. Software uses a simple single-cycle 32-bit register port with combinational read data.

Top module: `dmach_irq_regs`

## Requirements
- R1: After reset the status reads 0, the mask reads 0xFFF, both counters read 0 and irq_o is low.
- R2: Status bits [11:0] are sticky. Writing offset 0x00 clears each status bit written as 1 and leaves bits written as 0 unchanged. Status bits [31:12] read as zero.
- R3: A pulse on ev_i bit k sets status bit k for k in {3,6,7,8,9,10,11}. Bits 0, 1, 2, 4 and 5 of ev_i have no effect.
- R4: The mask at offset 0x04 is read-only. Writing offset 0x08 clears each mask bit written as 1. Writing offset 0x0C sets each mask bit written as 1. Offsets 0x08 and 0x0C read as zero.
- R5: irq_o is high exactly when some status bit is set while its mask bit is clear.
- R6: A src_done_i pulse sets status bit 1 and adds one to the source counter (offset 0x10). A dst_done_i pulse sets status bit 2 and adds one to the destination counter (offset 0x14).
- R7: An increment from 255 wraps the counter to 0. It also sets status bit 4 for the source counter or bit 5 for the destination counter.
- R8: A read of offset 0x10 or 0x14 returns the counter value and clears the counter to zero in the same cycle.
- R9: Any access to an offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 sets status bit 0. Such a read returns zero, and such a write changes nothing else.
- R10: An event and a write-1-to-clear that hit the same status bit in the same cycle leave the bit set.
- R11: A counter read that coincides with an increment of that counter returns the old value, and the counter then holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid during a read strobe |
| ev_i | input | 12 | Event pulses from the data mover, one per status bit position |
| src_done_i | input | 1 | Source descriptor completed with its interrupt flag set |
| dst_done_i | input | 1 | Destination descriptor completed with its interrupt flag set |
| irq_o | output | 1 | Level interrupt |

## Verification
Two kinds of collision can occur in one cycle. A hardware event can meet a software write-1-to-clear on the same status bit. A clear-on-read of a counter can meet an increment of that counter. The bench forces each collision by driving the event pulse and the register strobe on the same falling edge, so both land on one rising edge. It then reads the status bit or counter back through the register port and compares it with the event-wins and ends-at-one rules. The read data captured during the colliding read is checked against the pre-increment count.

// File: rtl/dmach_irq_pkg.sv
package dmach_irq_pkg;
  localparam int unsigned NUM_EV = 12;

  // status bit positions driven inside the block
  localparam int unsigned BIT_BAD_ACC  = 0;
  localparam int unsigned BIT_SRC_DONE = 1;
  localparam int unsigned BIT_DST_DONE = 2;
  localparam int unsigned BIT_SRC_WRAP = 4;
  localparam int unsigned BIT_DST_WRAP = 5;

  // bits that the external event input may set directly
  localparam logic [NUM_EV-1:0] EXT_EV_MASK = 12'hFC8;

  localparam int unsigned OFS_STATUS  = 'h00;
  localparam int unsigned OFS_MASK    = 'h04;
  localparam int unsigned OFS_UNMASK  = 'h08;
  localparam int unsigned OFS_DOMASK  = 'h0C;
  localparam int unsigned OFS_SRC_CNT = 'h10;
  localparam int unsigned OFS_DST_CNT = 'h14;

  typedef enum logic [2:0] {
    SEL_STATUS,
    SEL_MASK,
    SEL_UNMASK,
    SEL_DOMASK,
    SEL_SRC_CNT,
    SEL_DST_CNT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/dmach_irq_decode.sv
module dmach_irq_decode
  import dmach_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    case (addr_i)
      ADDR_W'(OFS_STATUS):  sel_o = SEL_STATUS;
      ADDR_W'(OFS_MASK):    sel_o = SEL_MASK;
      ADDR_W'(OFS_UNMASK):  sel_o = SEL_UNMASK;
      ADDR_W'(OFS_DOMASK):  sel_o = SEL_DOMASK;
      ADDR_W'(OFS_SRC_CNT): sel_o = SEL_SRC_CNT;
      ADDR_W'(OFS_DST_CNT): sel_o = SEL_DST_CNT;
      default:              sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/dmach_irq_status.sv
module dmach_irq_status #(
  parameter int unsigned NUM_EV = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] set_i,
  input  logic              w1c_i,
  input  logic              unmask_i,
  input  logic              domask_i,
  input  logic [NUM_EV-1:0] wdata_i,
  output logic [NUM_EV-1:0] status_o,
  output logic [NUM_EV-1:0] mask_o,
  output logic              irq_o
);
  logic [NUM_EV-1:0] status_q, status_d;
  logic [NUM_EV-1:0] mask_q, mask_d;
  logic              status_en, mask_en;

  // events are ORed in after the clear so a coincident event survives
  always_comb begin
    status_en = w1c_i | (|set_i);
    status_d  = (status_q & ~(w1c_i ? wdata_i : '0)) | set_i;
  end

  always_comb begin
    mask_en = unmask_i | domask_i;
    mask_d  = mask_q;
    if (unmask_i)      mask_d = mask_q & ~wdata_i;
    else if (domask_i) mask_d = mask_q | wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  p_unmask_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unmask_i |=> ((mask_q & $past(wdata_i)) == '0));

  p_domask_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (domask_i && !unmask_i) |=> ((mask_q & $past(wdata_i)) == $past(wdata_i)));

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dmach_irq_acct.sv
module dmach_irq_acct #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic             cnt_en;

  always_comb begin
    cnt_en = inc_i | clr_i;
    base   = clr_i ? '0 : cnt_q;
    cnt_d  = inc_i ? base + CNT_W'(1) : base;
    wrap_o = inc_i & ~clr_i & (cnt_q == CNT_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_wrap_to_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && (cnt_q == CNT_MAX)) |=> (cnt_q == '0));

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !inc_i) |=> (cnt_q == '0));

  p_clear_and_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && inc_i) |=> (cnt_q == CNT_W'(1)));
endmodule

// File: rtl/dmach_irq_regs.sv
module dmach_irq_regs
  import dmach_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [11:0]       ev_i,
  input  logic              src_done_i,
  input  logic              dst_done_i,
  output logic              irq_o
);
  localparam int unsigned NUM_CNT = 2;

  reg_sel_e          sel;
  logic              rd_stb, wr_stb, bad_acc;
  logic [NUM_EV-1:0] set_vec, status_w, mask_w;
  logic [NUM_CNT-1:0] cnt_inc, cnt_clr, cnt_wrap;
  logic [CNT_W-1:0]  cnt_val [NUM_CNT];
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[DATA_W-1:NUM_EV];

  dmach_irq_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  always_comb begin
    rd_stb  = req_i & ~wr_i;
    wr_stb  = req_i & wr_i;
    bad_acc = req_i & (sel == SEL_NONE);
  end

  assign cnt_inc = {dst_done_i, src_done_i};
  assign cnt_clr = {rd_stb & (sel == SEL_DST_CNT), rd_stb & (sel == SEL_SRC_CNT)};

  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_acct
    dmach_irq_acct #(.CNT_W(CNT_W)) u_acct (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc_i  (cnt_inc[gi]),
      .clr_i  (cnt_clr[gi]),
      .cnt_o  (cnt_val[gi]),
      .wrap_o (cnt_wrap[gi])
    );
  end

  always_comb begin
    set_vec               = ev_i & EXT_EV_MASK;
    set_vec[BIT_BAD_ACC]  = bad_acc;
    set_vec[BIT_SRC_DONE] = src_done_i;
    set_vec[BIT_DST_DONE] = dst_done_i;
    set_vec[BIT_SRC_WRAP] = cnt_wrap[0];
    set_vec[BIT_DST_WRAP] = cnt_wrap[1];
  end

  dmach_irq_status #(.NUM_EV(NUM_EV)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (set_vec),
    .w1c_i    (wr_stb & (sel == SEL_STATUS)),
    .unmask_i (wr_stb & (sel == SEL_UNMASK)),
    .domask_i (wr_stb & (sel == SEL_DOMASK)),
    .wdata_i  (wdata_i[NUM_EV-1:0]),
    .status_o (status_w),
    .mask_o   (mask_w),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_stb) begin
      case (sel)
        SEL_STATUS:  rdata_o[NUM_EV-1:0] = status_w;
        SEL_MASK:    rdata_o[NUM_EV-1:0] = mask_w;
        SEL_SRC_CNT: rdata_o[CNT_W-1:0]  = cnt_val[0];
        SEL_DST_CNT: rdata_o[CNT_W-1:0]  = cnt_val[1];
        default:     rdata_o = '0;
      endcase
    end
  end

  p_bad_access_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && (sel == SEL_NONE)) |=> status_w[BIT_BAD_ACC]);

  p_bad_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && (sel == SEL_NONE)) |-> (rdata_o == '0));
endmodule

// File: tb/test_dmach_irq_regs.sv
module test_dmach_irq_regs;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic [11:0] ev;
  logic        src_done, dst_done, irq;

  int errs = 0;
  int checks = 0;
  logic [31:0] rv;

  always #(CLK_NS/2) clk = ~clk;

  dmach_irq_regs i_dmach_irq_regs (
    .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ev_i(ev), .src_done_i(src_done),
    .dst_done_i(dst_done), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic pulse(input logic [11:0] e, input logic s, input logic dd, input int n);
    @(negedge clk);
    ev = e; src_done = s; dst_done = dd;
    repeat (n) @(negedge clk);
    ev = '0; src_done = 1'b0; dst_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    ev = '0; src_done = 1'b0; dst_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(8'h00, rv); chk("R1 status", rv, 32'h0);
    reg_rd(8'h04, rv); chk("R1 mask", rv, 32'hFFF);
    reg_rd(8'h10, rv); chk("R1 src count", rv, 32'h0);
    reg_rd(8'h14, rv); chk("R1 dst count", rv, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);

    // R4 command offsets read zero, mask not directly writable
    reg_rd(8'h08, rv); chk("R4 unmask reads 0", rv, 32'h0);
    reg_rd(8'h0C, rv); chk("R4 domask reads 0", rv, 32'h0);
    reg_wr(8'h04, 32'h0);
    reg_rd(8'h04, rv); chk("R4 mask read-only", rv, 32'hFFF);

    // sweep every status bit position
    for (int k = 0; k < 12; k++) begin
      logic [31:0] bit_k, exp_st;
      bit_k  = 32'h1 << k;
      exp_st = ((32'hFC8 >> k) & 1) != 0 ? bit_k : 32'h0;
      pulse(bit_k[11:0], 1'b0, 1'b0, 1);
      reg_rd(8'h00, rv); chk("R3 event sets bit", rv, exp_st);
      chk("R5 masked no irq", {31'h0, irq}, 32'h0);
      reg_wr(8'h08, bit_k);
      reg_rd(8'h04, rv); chk("R4 unmask bit", rv, 32'hFFF & ~bit_k);
      chk("R5 irq follows", {31'h0, irq}, {31'h0, exp_st != 0});
      reg_wr(8'h00, 32'hFFFFF000 | (32'hFFF & ~bit_k));
      reg_rd(8'h00, rv); chk("R2 other bits keep", rv, exp_st);
      reg_wr(8'h00, bit_k);
      reg_rd(8'h00, rv); chk("R2 w1c clears", rv, 32'h0);
      chk("R5 irq drops", {31'h0, irq}, 32'h0);
      reg_wr(8'h0C, bit_k);
      reg_rd(8'h04, rv); chk("R4 domask bit", rv, 32'hFFF);
    end

    // accounting counters: which=0 source, which=1 destination
    for (int which = 0; which < 2; which++) begin
      logic [31:0] done_b, wrap_b;
      logic [7:0]  ca;
      done_b = 32'h1 << (1 + which);
      wrap_b = 32'h1 << (4 + which);
      ca = 8'h10 + 8'(4 * which);
      reg_wr(8'h00, 32'hFFF);
      pulse('0, which == 0, which == 1, 255);
      reg_rd(8'h00, rv); chk("R6 done bit, no wrap", rv, done_b);
      reg_rd(ca, rv); chk("R6 count 255", rv, 32'd255);
      reg_rd(ca, rv); chk("R8 cleared by read", rv, 32'd0);
      pulse('0, which == 0, which == 1, 300);
      reg_rd(8'h00, rv); chk("R7 wrap sets bit", rv, done_b | wrap_b);
      reg_rd(ca, rv); chk("R7 count after wrap", rv, 32'd300 % 256);
      reg_wr(8'h08, wrap_b);
      chk("R5 wrap irq", {31'h0, irq}, 32'h1);
      reg_wr(8'h0C, wrap_b);
      reg_wr(8'h00, 32'hFFF);
    end

    // R9 undecoded offsets
    reg_rd(8'h18, rv); chk("R9 undecoded read 0", rv, 32'h0);
    reg_rd(8'h00, rv); chk("R9 flag on read", rv, 32'h1);
    reg_wr(8'h00, 32'h1);
    reg_wr(8'h20, 32'hFFF);
    reg_rd(8'h00, rv); chk("R9 write dropped, flag", rv, 32'h1);
    reg_rd(8'h04, rv); chk("R9 mask untouched", rv, 32'hFFF);
    reg_wr(8'h00, 32'h1);
    reg_rd(8'h02, rv); chk("R9 misaligned read 0", rv, 32'h0);
    reg_rd(8'h00, rv); chk("R9 misaligned flag", rv, 32'h1);
    reg_wr(8'h00, 32'h1);

    // R10 event meets w1c on same bit (bit 8), clear on bit 9 still works
    pulse(12'h200, 1'b0, 1'b0, 1);
    @(negedge clk);
    ev = 12'h100; req = 1'b1; wr = 1'b1; addr = 8'h00; wdata = 32'h300;
    @(negedge clk);
    ev = '0; req = 1'b0; wr = 1'b0; wdata = '0;
    reg_rd(8'h00, rv); chk("R10 event wins", rv, 32'h100);
    reg_wr(8'h00, 32'h100);

    // R11 read-clear meets increment
    pulse('0, 1'b1, 1'b0, 3);
    @(negedge clk);
    req = 1'b1; wr = 1'b0; addr = 8'h10; src_done = 1'b1;
    #1 rv = rdata;
    @(negedge clk);
    req = 1'b0; src_done = 1'b0;
    chk("R11 read returns old", rv, 32'd3);
    reg_rd(8'h10, rv); chk("R11 ends at one", rv, 32'd1);

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule